// File: doc/BRIEF.md
# Multichannel SAR ADC SPI Reader

This block is an SPI master that fetches one conversion result from a successive-approximation converter. A client pulses `req` with a channel number and a differential flag. The reader then drops chip select and runs one frame. A multichannel converter first gets a command byte and then returns two data bytes. A single-channel converter has no data input, so the frame carries only the two returned bytes. When the frame ends, the reader slices the result out of the 16 received bits, right-aligns it and presents it with a one-cycle `result_valid` pulse.

The converter variant is fixed at build time by two parameters: the channel count (1, 2, 4 or 8) and the resolution (10, 12 or 13 bits; 13 only with one channel). The 13-bit part returns a two's-complement value, which the reader sign-extends to the result width. The serial clock is derived from the system clock by a parameterised divider.

Top module: `sar_adc_spi_reader`

## Requirements
- R1: During and after reset, with no request, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy` and `result_valid` are 0.
- R2: With 2 channels the command byte, sent MSB first, has bit 4 = 1 (start), bit 3 = NOT `req_diff`, and bit 2 = `req_chan[0]`; the other bits are 0 and the upper channel bits are ignored.
- R3: With 4 or 8 channels the command byte has bit 6 = 1 (start), bit 5 = NOT `req_diff`, and bits 4:2 = the channel masked to the channel count; the other bits are 0. In differential mode the channel names an even/odd pair, and its low bit picks which member is the positive input.
- R4: One request makes exactly one frame with `spi_cs_n` low. The frame has 24 SCLK rising edges with a command byte, or 16 without one. There is no SCLK edge while `spi_cs_n` is high.
- R5: Single-channel variants send no command, and `spi_mosi` stays 0 for the whole frame.
- R6: 10-bit multichannel: with received bytes b0 then b1, the result is (b0<<2 | b1>>6) over 10 bits, zero-extended.
- R7: 12-bit multichannel: the result is (b0<<4 | b1>>4) over 12 bits, zero-extended.
- R8: Single-channel 10-bit: the result is (b0<<5 | b1>>3), masked to 10 bits. Single-channel 12-bit: the result is (b0<<7 | b1>>1), masked to 12 bits.
- R9: 13-bit variant: the result is b0[4:0] followed by b1, sign-extended from bit 12 to 16 bits. The top three bits of b0 are ignored.
- R10: `busy` rises the cycle after an accepted request and falls in the cycle where `result_valid` pulses high for exactly one cycle. A request made while busy is ignored.
- R11: SPI mode 0: SCLK idles low, MOSI does not change while SCLK is high, and MISO is sampled at the SCLK rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request strobe |
| req_chan | input | 3 | Channel or pair selector |
| req_diff | input | 1 | 1 = differential, 0 = single-ended |
| busy | output | 1 | Frame in progress |
| result_valid | output | 1 | One-cycle result strobe |
| result | output | 16 | Right-aligned sample (sign-extended for 13-bit) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Command data to converter |
| spi_miso | input | 1 | Sample data from converter |

## Verification
The bench targets the misaligned slicing of each variant with all-ones words, where a wrong shift or mask leaks high bits into the result. It also covers words whose upper bits of the first byte are set on the 13-bit part, where a design that forgets to mask before sign extension returns a wrong negative value. Channel numbers above the channel count check that a design without masking does not corrupt the start or mode bits of the command. A second request sent in the middle of a frame catches a reader that restarts or drops the first result. The converter model changes MISO right after each rising edge, so a reader that samples on the falling edge gets every bit one place off.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    localparam int RESULT_W = 16;
    localparam int CHAN_W   = 3;

    typedef enum logic {
        RD_IDLE,
        RD_SHIFT
    } rd_state_e;

    // Command byte for the chosen channel count; zero for receive-only parts.
    function automatic logic [7:0] build_cmd(input int num_ch,
                                             input logic [CHAN_W-1:0] ch,
                                             input logic diff);
        logic [7:0]        c;
        logic [CHAN_W-1:0] sel;
        c   = '0;
        sel = ch & CHAN_W'(num_ch - 1);
        if (num_ch == 2) begin
            c[4] = 1'b1;
            c[3] = ~diff;
            c[2] = sel[0];
        end else if (num_ch > 2) begin
            c[6]   = 1'b1;
            c[5]   = ~diff;
            c[4:2] = sel;
        end
        return c;
    endfunction

    // Right shift that aligns the sample inside the 16-bit receive window.
    function automatic int slice_shift(input int num_ch, input int res);
        return (num_ch == 1) ? (13 - res) : (16 - res);
    endfunction

endpackage

// File: rtl/sar_rd_tick.sv
module sar_rd_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || cnt == LAST) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/sar_rd_serdes.sv
module sar_rd_serdes #(
    parameter int CMD_BITS = 8,
    parameter int RX_BITS  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               tick,
    input  logic [7:0]         cmd_in,
    input  logic               miso,
    output logic               active,
    output logic               sclk,
    output logic               mosi,
    output logic               done,
    output logic [RX_BITS-1:0] rx_word
);
    localparam int TOTAL = CMD_BITS + RX_BITS;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOTAL - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       tx_sr;
    logic             in_cmd;

    generate
        if (CMD_BITS == 0) begin : g_rx_only
            assign in_cmd = 1'b0;
        end else begin : g_with_cmd
            assign in_cmd = (bit_cnt < CNT_W'(CMD_BITS));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                sclk    <= 1'b0;
                bit_cnt <= '0;
                tx_sr   <= cmd_in;
                rx_word <= '0;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    if (!in_cmd) rx_word <= {rx_word[RX_BITS-2:0], miso};
                end else begin
                    sclk  <= 1'b0;
                    tx_sr <= {tx_sr[6:0], 1'b0};
                    if (bit_cnt == LAST_BIT) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign mosi = active & in_cmd & tx_sr[7];

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sclk); // R11
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R11
endmodule

// File: rtl/sar_rd_slice.sv
module sar_rd_slice
    import sar_rd_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 12
) (
    input  logic [15:0]         rx_word,
    output logic [RESULT_W-1:0] value
);
    localparam int SHIFT = slice_shift(NUM_CH, RES_BITS);
    localparam logic [15:0] MASK = 16'((32'd1 << RES_BITS) - 1);
    localparam bit SIGNED_OUT = (NUM_CH == 1) && (RES_BITS == 13);
    localparam int LIFT = 16 - RES_BITS;

    generate
        if (SIGNED_OUT) begin : g_signed
            logic signed [15:0] lifted;
            assign lifted = $signed(rx_word << LIFT);
            assign value  = RESULT_W'(lifted >>> LIFT);
        end else begin : g_unsigned
            assign value = RESULT_W'((rx_word >> SHIFT) & MASK);
        end
    endgenerate
endmodule

// File: rtl/sar_adc_spi_reader.sv
module sar_adc_spi_reader
    import sar_rd_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 12,
    parameter int CLK_DIV  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic                req_diff,
    output logic                busy,
    output logic                result_valid,
    output logic [RESULT_W-1:0] result,
    output logic                spi_sclk,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    localparam int CMD_BITS = (NUM_CH > 1) ? 8 : 0;
    localparam int RX_BYTES = (RES_BITS + 7) / 8;
    localparam int RX_BITS  = 8 * RX_BYTES;

    rd_state_e           state;
    logic                start;
    logic                tick;
    logic                active;
    logic                done;
    logic [7:0]          cmd;
    logic [RX_BITS-1:0]  rx_word;
    logic [RESULT_W-1:0] sliced;

    assign start = (state == RD_IDLE) && req;
    assign cmd   = build_cmd(NUM_CH, req_chan, req_diff);

    sar_rd_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .tick (tick)
    );

    sar_rd_serdes #(.CMD_BITS(CMD_BITS), .RX_BITS(RX_BITS)) u_serdes (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tick    (tick),
        .cmd_in  (cmd),
        .miso    (spi_miso),
        .active  (active),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (done),
        .rx_word (rx_word)
    );

    sar_rd_slice #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_slice (
        .rx_word (rx_word),
        .value   (sliced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= RD_IDLE;
            result_valid <= 1'b0;
            result       <= '0;
        end else begin
            result_valid <= 1'b0;
            case (state)
                RD_IDLE:  if (req) state <= RD_SHIFT;
                RD_SHIFT: if (done) begin
                    state        <= RD_IDLE;
                    result       <= sliced;
                    result_valid <= 1'b1;
                end
                default:  state <= RD_IDLE;
            endcase
        end
    end

    assign busy     = (state == RD_SHIFT);
    assign spi_cs_n = ~active;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid); // R10
    AST_BUSY_DROP_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> result_valid); // R10
    AST_SHIFT_EXITS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || result_valid)); // R10
    AST_NO_SCLK_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R4
endmodule

// File: tb/sar_adc_spi_reader_tb_top.sv
`timescale 1ns/1ps

module sar_adc_slave_model #(
    parameter int TOTAL = 24
) (
    input  logic        arm,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        mosi,
    input  logic [23:0] pattern,
    output logic        miso,
    output logic [7:0]  cmd_seen,
    output logic [7:0]  edges,
    output logic [7:0]  stray,
    output logic        mosi_any
);
    initial begin
        cmd_seen = '0; edges = '0; stray = '0; mosi_any = 1'b0;
    end

    always @(posedge sclk or posedge arm) begin
        if (arm) begin
            cmd_seen = '0; edges = '0; stray = '0; mosi_any = 1'b0;
        end else if (cs_n) begin
            stray = stray + 8'd1;
        end else begin
            if (edges < 8) cmd_seen = {cmd_seen[6:0], mosi};
            mosi_any = mosi_any | mosi;
            edges    = edges + 8'd1;
        end
    end

    assign miso = (int'(edges) < TOTAL) ? pattern[TOTAL - 1 - int'(edges)] : 1'b0;
endmodule

module sar_adc_spi_reader_tb_top;
    localparam int LANES = 6;
    localparam int NCH [LANES] = '{8, 2, 1, 1, 1, 4};
    localparam int RES [LANES] = '{12, 10, 10, 12, 13, 10};
    localparam int DIV [LANES] = '{4, 2, 3, 2, 4, 2};
    localparam int NVEC = 17;
    // {lane[46:44], chan[43:41], diff[40], word[39:24], cmd[23:16], expected[15:0]}
    localparam logic [46:0] VEC [NVEC] = '{
        {3'd0, 3'd5, 1'b0, 16'hABCD, 8'h74, 16'h0ABC},
        {3'd0, 3'd3, 1'b1, 16'h0FF0, 8'h4C, 16'h00FF},
        {3'd0, 3'd7, 1'b0, 16'hFFFF, 8'h7C, 16'h0FFF},
        {3'd1, 3'd1, 1'b0, 16'h02C0, 8'h1C, 16'h000B},
        {3'd1, 3'd0, 1'b1, 16'hFFFF, 8'h10, 16'h03FF},
        {3'd1, 3'd3, 1'b0, 16'h0040, 8'h1C, 16'h0001},
        {3'd5, 3'd2, 1'b1, 16'h5540, 8'h48, 16'h0155},
        {3'd5, 3'd3, 1'b0, 16'h0000, 8'h6C, 16'h0000},
        {3'd5, 3'd6, 1'b1, 16'h8000, 8'h48, 16'h0200},
        {3'd2, 3'd0, 1'b0, 16'h1A58, 8'h00, 16'h034B},
        {3'd2, 3'd5, 1'b1, 16'hFFFF, 8'h00, 16'h03FF},
        {3'd3, 3'd0, 1'b0, 16'h0ACE, 8'h00, 16'h0567},
        {3'd3, 3'd0, 1'b0, 16'hFFFF, 8'h00, 16'h0FFF},
        {3'd4, 3'd0, 1'b0, 16'h0FFF, 8'h00, 16'h0FFF},
        {3'd4, 3'd0, 1'b0, 16'hF001, 8'h00, 16'hF001},
        {3'd4, 3'd0, 1'b0, 16'hE000, 8'h00, 16'h0000},
        {3'd4, 3'd0, 1'b0, 16'h1FFF, 8'h00, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  chan = '0;
    logic        diff = 1'b0;
    logic        req      [LANES];
    logic        arm      [LANES];
    logic [23:0] pat      [LANES];
    logic        busy_w   [LANES];
    logic        valid_w  [LANES];
    logic [15:0] res_w    [LANES];
    logic        sclk_w   [LANES];
    logic        cs_w     [LANES];
    logic        mosi_w   [LANES];
    logic        miso_w   [LANES];
    logic [7:0]  cmd_w    [LANES];
    logic [7:0]  edge_w   [LANES];
    logic [7:0]  stray_w  [LANES];
    logic        many_w   [LANES];

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    for (genvar g = 0; g < LANES; g++) begin : gen_lane
        sar_adc_spi_reader #(.NUM_CH(NCH[g]), .RES_BITS(RES[g]), .CLK_DIV(DIV[g])) dut_i (
            .clk          (clk),
            .rst          (rst),
            .req          (req[g]),
            .req_chan     (chan),
            .req_diff     (diff),
            .busy         (busy_w[g]),
            .result_valid (valid_w[g]),
            .result       (res_w[g]),
            .spi_sclk     (sclk_w[g]),
            .spi_cs_n     (cs_w[g]),
            .spi_mosi     (mosi_w[g]),
            .spi_miso     (miso_w[g])
        );
        sar_adc_slave_model #(.TOTAL(NCH[g] > 1 ? 24 : 16)) slave_i (
            .arm      (arm[g]),
            .cs_n     (cs_w[g]),
            .sclk     (sclk_w[g]),
            .mosi     (mosi_w[g]),
            .pattern  (pat[g]),
            .miso     (miso_w[g]),
            .cmd_seen (cmd_w[g]),
            .edges    (edge_w[g]),
            .stray    (stray_w[g]),
            .mosi_any (many_w[g])
        );
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string result_tag(input int k);
        case (k)
            0:       return "R7";
            1, 5:    return "R6";
            4:       return "R9";
            default: return "R8";
        endcase
    endfunction

    function automatic string cmd_tag(input int k);
        case (k)
            1:       return "R2";
            0, 5:    return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic do_read(input int k, input logic [2:0] ch, input logic d,
                           input logic [15:0] word, input bit poke,
                           output logic [15:0] res, output bit timed_out);
        int n;
        pat[k] = (NCH[k] > 1) ? {8'hFF, word} : {8'h00, word};
        arm[k] = 1'b1;
        #1 arm[k] = 1'b0;
        @(negedge clk);
        req[k] = 1'b1; chan = ch; diff = d;
        @(negedge clk);
        req[k] = 1'b0;
        check(busy_w[k] === 1'b1, "R10", "busy after request", int'(busy_w[k]), 1);
        n = 0;
        timed_out = 1'b0;
        while (valid_w[k] !== 1'b1 && n < 4000) begin
            if (poke && n == 30) begin
                req[k] = 1'b1; chan = ~ch; diff = ~d;
            end else begin
                req[k] = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req[k] = 1'b0;
        if (n >= 4000) timed_out = 1'b1;
        res = res_w[k];
        if (poke)
            check(busy_w[k] === 1'b0, "R10", "busy low with valid", int'(busy_w[k]), 0);
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] res;
        bit          to;
        for (int i = 0; i < LANES; i++) begin
            req[i] = 1'b0; arm[i] = 1'b0; pat[i] = '0;
        end
        repeat (3) @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            check(cs_w[i] === 1'b1 && sclk_w[i] === 1'b0, "R1", "cs_n/sclk in reset",
                  {cs_w[i], sclk_w[i]}, 2'b10);
            check(busy_w[i] === 1'b0 && valid_w[i] === 1'b0, "R1", "busy/valid in reset",
                  {busy_w[i], valid_w[i]}, 0);
        end
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(cs_w[0] === 1'b1 && busy_w[0] === 1'b0 && valid_w[0] === 1'b0, "R1",
              "idle after reset", {cs_w[0], busy_w[0], valid_w[0]}, 3'b100);

        // Vector table: result slicing, command encoding, frame length.
        for (int i = 0; i < NVEC; i++) begin
            int k;
            k = int'(VEC[i][46:44]);
            do_read(k, VEC[i][43:41], VEC[i][40], VEC[i][39:24], 1'b0, res, to);
            check(!to, "R10", "result_valid timeout", int'(to), 0);
            // R11: the model moves MISO right after each rising edge.
            check(res === VEC[i][15:0], result_tag(k), "result", res, VEC[i][15:0]);
            if (NCH[k] > 1)
                check(cmd_w[k] === VEC[i][23:16], cmd_tag(k), "command byte",
                      cmd_w[k], VEC[i][23:16]);
            else
                check(many_w[k] === 1'b0, "R5", "mosi activity", int'(many_w[k]), 0);
            check(edge_w[k] === 8'((NCH[k] > 1) ? 24 : 16), "R4", "sclk edges",
                  edge_w[k], (NCH[k] > 1) ? 24 : 16);
            check(stray_w[k] === 8'd0, "R4", "edges while deselected", stray_w[k], 0);
        end

        // R10: request mid-frame is ignored; valid lasts one cycle.
        do_read(0, 3'd6, 1'b0, 16'h1234, 1'b1, res, to);
        check(!to, "R10", "timeout on poked frame", int'(to), 0);
        check(res === 16'h0123, "R10", "result after ignored request", res, 16'h0123);
        check(cmd_w[0] === 8'h78, "R10", "command after ignored request", cmd_w[0], 8'h78);
        @(negedge clk);
        check(valid_w[0] === 1'b0, "R10", "valid width", int'(valid_w[0]), 0);
        repeat (40) @(negedge clk);
        check(busy_w[0] === 1'b0 && cs_w[0] === 1'b1, "R10", "no second frame",
              {busy_w[0], cs_w[0]}, 2'b01);
        check(edge_w[0] === 8'd24 && stray_w[0] === 8'd0, "R4", "single frame edges",
              edge_w[0], 24);
        check(res_w[0] === 16'h0123, "R10", "result held", res_w[0], 16'h0123);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule